// File: doc/BRIEF.md
# Flow-Through Synchronous Burst SRAM

This block is a cycle-level, synthesizable model of a synchronous static RAM whose reads are flow-through. A memory controller or processor sits in front of it. Address, chip enables, burst controls, write controls and write data are all captured on the rising clock edge. Read data for the captured address comes out of the array in the same cycle, with no added pipeline register. This gives a 2-1-1-1 access pattern for a four-beat burst.

A burst is opened by either of two address strobes. The processor-side strobe needs only the primary enable and always opens a read. The controller-side strobe needs all three enables and can open a read or a write. After that, a 2-bit counter supplies the low address bits. The counter moves in linear or interleaved order and steps only when the advance input is high. A byte-write enable with per-lane strobes writes chosen byte lanes. A global write stores the whole word. Output enable gates the read data without waiting for a clock edge. The sleep input idles the device two clock edges after it is seen, and the stored contents are kept.

Top module: `fts_sram`

## Requirements
- R1: A controller-side strobe (`strobe_ctl`=1) with `en_a`=1, `en_b`=1 and `en_c`=1, and with no accepted processor-side start, opens a burst at `addr`. If no write is requested, `rdata_vld` is 1 right after that edge and `rdata` holds the word at `addr`.
- R2: With `interleave`=0, each edge in a burst that has `adv`=1 adds 1 modulo 4 to the two low address bits. A burst starting at low bits 2 reads 2,3,0,1.
- R3: With `interleave`=1, the low address bits equal the starting low bits XOR the step count. A burst starting at low bits 1 reads 1,0,3,2.
- R4: In a burst, an edge with no accepted strobe and `adv`=0 keeps the current address, for reads and for writes.
- R5: A new external address may be loaded on every edge. Back-to-back strobed writes and reads each complete in one cycle.
- R6: When `byte_we`=1 and `all_we`=0, only the lanes with `lane_we[i]`=1 are written. Lane i is `wdata[8i+7:8i]`. `byte_we`=1 with `lane_we`=0 is a read.
- R7: `all_we`=1 writes every lane of the word, whatever `byte_we` and `lane_we` are.
- R8: A processor-side strobe (`strobe_cpu`=1) with `en_a`=1 opens a read at `addr`, whatever `en_b`, `en_c`, `strobe_ctl` and the write controls are. It takes priority over the controller-side strobe.
- R9: A processor-side strobe with `en_a`=0 is ignored, so the edge follows the other rules. For example, an active burst advances.
- R10: A controller-side strobe with any enable low deselects the device. `rdata_vld` stays 0 until a new burst is accepted, even when `adv` is high.
- R11: With `out_en`=0, `rdata_vld` and `rdata` are 0 at once, without a clock edge.
- R12: When `sleep` goes high at edge k, commands at edge k+2 and later are ignored and `rdata_vld` is 0 from after edge k+1. The stored words are kept and can be read after wake-up.
- R13: After reset the device is deselected and `rdata_vld` is 0.
- R14: Address bits above the two low bits stay fixed for the whole burst, including when the low bits wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| addr | input | ADDR_W | External word address |
| en_a | input | 1 | Primary chip enable, active high |
| en_b | input | 1 | Second chip enable, used only with the controller-side strobe |
| en_c | input | 1 | Third chip enable, used only with the controller-side strobe |
| strobe_cpu | input | 1 | Processor-side address strobe (read start) |
| strobe_ctl | input | 1 | Controller-side address strobe (read or write start) |
| adv | input | 1 | Burst advance |
| lane_we | input | BYTES | Per-lane write strobes |
| byte_we | input | 1 | Byte-write enable |
| all_we | input | 1 | Global write, all lanes |
| out_en | input | 1 | Asynchronous output enable |
| interleave | input | 1 | Burst order: 0 linear, 1 interleaved |
| sleep | input | 1 | Sleep request |
| wdata | input | 8*BYTES | Write data |
| rdata | output | 8*BYTES | Read data, 0 when not valid |
| rdata_vld | output | 1 | Read data valid |

## Verification
Bursts are read from starting low bits 2 and 1 in both orders. Starting low bits 2 in linear order and 1 in interleaved order give sequences that differ at every beat, so a swapped or shared order shows up. The wrap beats also expose any carry into the upper address bits. Write bursts with advance held low, then high, separate holding from stepping. Lane patterns 0101 and 0000, with and without the global write, separate the byte-write path from the global path. Strobe pairs with one enable low each give a different outcome: processor strobe with the secondary enables low, processor strobe with the primary enable low, and controller strobe with one enable low. This shows the priority and the enable rules are decoded apart.

// File: rtl/fts_pkg.sv
package fts_pkg;
  localparam int unsigned LANE_W = 8;

  // low two address bits of a burst beat
  function automatic logic [1:0] beat_low(input logic [1:0] base,
                                          input logic [1:0] step,
                                          input logic       ilv);
    return ilv ? (base ^ step) : (base + step);
  endfunction
endpackage

// File: rtl/fts_burst_addr.sv
module fts_burst_addr #(
  parameter int unsigned ADDR_W = 8
) (
  input  logic [ADDR_W-3:0] upper,
  input  logic [1:0]        base,
  input  logic [1:0]        step,
  input  logic              ilv,
  output logic [ADDR_W-1:0] word_addr
);
  import fts_pkg::*;
  always_comb word_addr = {upper, beat_low(base, step, ilv)};
endmodule

// File: rtl/fts_mem_array.sv
module fts_mem_array #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned BYTES  = 4
) (
  input  logic                          clk,
  input  logic                          wr_en,
  input  logic [ADDR_W-1:0]             wr_addr,
  input  logic [BYTES-1:0]              wr_mask,
  input  logic [fts_pkg::LANE_W*BYTES-1:0] wr_data,
  input  logic [ADDR_W-1:0]             rd_addr,
  output logic [fts_pkg::LANE_W*BYTES-1:0] rd_data
);
  import fts_pkg::*;
  localparam int unsigned DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < BYTES; g++) begin : g_lane
    logic [LANE_W-1:0] cells [DEPTH];
    logic              lane_en;
    assign lane_en = wr_en & wr_mask[g];
    always_ff @(posedge clk) begin
      if (lane_en) cells[wr_addr] <= wr_data[LANE_W*g +: LANE_W];
    end
    assign rd_data[LANE_W*g +: LANE_W] = cells[rd_addr];
  end
endmodule

// File: rtl/fts_cycle_ctl.sv
module fts_cycle_ctl #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned BYTES  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              en_a,
  input  logic              en_b,
  input  logic              en_c,
  input  logic              strobe_cpu,
  input  logic              strobe_ctl,
  input  logic              adv,
  input  logic [BYTES-1:0]  lane_we,
  input  logic              byte_we,
  input  logic              all_we,
  input  logic              interleave,
  input  logic              sleep,
  output logic              rd_cycle,
  output logic              asleep,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [BYTES-1:0]  wr_mask
);
  localparam int unsigned UP_W = ADDR_W - 2;

  logic [1:0]      rs_q;
  logic            rst_int_n;
  logic [1:0]      slp_q;
  logic            act_q, act_d;
  logic            wr_q, wr_d;
  logic [UP_W-1:0] up_q, up_d;
  logic [1:0]      base_q, base_d;
  logic [1:0]      cnt_q, cnt_d;
  logic            st_en;
  logic            cpu_go, ctl_go, ctl_sel, wr_req;

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_int_n = rs_q[1];

  // sleep request takes two edges to become effective
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) slp_q <= 2'b00;
    else            slp_q <= {slp_q[0], sleep};
  end
  assign asleep = slp_q[1];

  // cycle decode
  assign cpu_go  = strobe_cpu & en_a;
  assign ctl_go  = ~cpu_go & strobe_ctl;
  assign ctl_sel = en_a & en_b & en_c;
  assign wr_req  = all_we | (byte_we & (|lane_we));

  always_comb begin
    act_d  = act_q;
    wr_d   = wr_q;
    up_d   = up_q;
    base_d = base_q;
    cnt_d  = cnt_q;
    if (asleep) begin
      act_d = 1'b0;
    end else if (cpu_go) begin
      act_d  = 1'b1;
      wr_d   = 1'b0;
      up_d   = addr[ADDR_W-1:2];
      base_d = addr[1:0];
      cnt_d  = 2'd0;
    end else if (ctl_go) begin
      act_d = ctl_sel;
      if (ctl_sel) begin
        wr_d   = wr_req;
        up_d   = addr[ADDR_W-1:2];
        base_d = addr[1:0];
        cnt_d  = 2'd0;
      end
    end else if (act_q) begin
      wr_d = wr_req;
      if (adv) cnt_d = cnt_q + 2'd1;
    end
  end

  assign st_en = ~asleep | act_q;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      act_q  <= 1'b0;
      wr_q   <= 1'b0;
      up_q   <= '0;
      base_q <= 2'd0;
      cnt_q  <= 2'd0;
    end else if (st_en) begin
      act_q  <= act_d;
      wr_q   <= wr_d;
      up_q   <= up_d;
      base_q <= base_d;
      cnt_q  <= cnt_d;
    end
  end

  // address of the beat being written at this edge, and of the beat read now
  fts_burst_addr #(.ADDR_W(ADDR_W)) u_wr_addr (
    .upper(up_d), .base(base_d), .step(cnt_d), .ilv(interleave), .word_addr(wr_addr)
  );
  fts_burst_addr #(.ADDR_W(ADDR_W)) u_rd_addr (
    .upper(up_q), .base(base_q), .step(cnt_q), .ilv(interleave), .word_addr(rd_addr)
  );

  assign wr_en    = ~asleep & act_d & wr_d;
  assign wr_mask  = all_we ? {BYTES{1'b1}} : lane_we;
  assign rd_cycle = act_q & ~wr_q;

  // R8: processor-side start is always a read
  a_r8_cpu_read: assert property (@(posedge clk) disable iff (!rst_int_n)
    (strobe_cpu && en_a && !asleep) |=> (rd_cycle && rd_addr[1:0] == $past(addr[1:0])));
  // R2: advancing steps the counter by one
  a_r2_step: assert property (@(posedge clk) disable iff (!rst_int_n)
    (act_q && !strobe_cpu && !strobe_ctl && adv && !asleep) |=> (cnt_q == $past(cnt_q) + 2'd1));
  // R4: no advance keeps the address
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_int_n)
    (act_q && !strobe_cpu && !strobe_ctl && !adv && !asleep) |=> $stable(rd_addr));
  // R14: upper bits fixed during a burst
  a_r14_upper: assert property (@(posedge clk) disable iff (!rst_int_n)
    (act_q && !strobe_cpu && !strobe_ctl && !asleep) |=> $stable(rd_addr[ADDR_W-1:2]));
  // R10: partial enables deselect
  a_r10_desel: assert property (@(posedge clk) disable iff (!rst_int_n)
    (strobe_ctl && !(strobe_cpu && en_a) && !(en_a && en_b && en_c)) |=> !rd_cycle);
  // R12: asleep means idle afterwards
  a_r12_idle: assert property (@(posedge clk) disable iff (!rst_int_n)
    asleep |=> !act_q);
endmodule

// File: rtl/fts_sram.sv
module fts_sram #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned BYTES  = 4,
  localparam int unsigned DATA_W = fts_pkg::LANE_W * BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              en_a,
  input  logic              en_b,
  input  logic              en_c,
  input  logic              strobe_cpu,
  input  logic              strobe_ctl,
  input  logic              adv,
  input  logic [BYTES-1:0]  lane_we,
  input  logic              byte_we,
  input  logic              all_we,
  input  logic              out_en,
  input  logic              interleave,
  input  logic              sleep,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rdata_vld
);
  logic              rd_cycle, asleep, wr_en;
  logic [ADDR_W-1:0] rd_addr, wr_addr;
  logic [BYTES-1:0]  wr_mask;
  logic [DATA_W-1:0] arr_q;

  fts_cycle_ctl #(.ADDR_W(ADDR_W), .BYTES(BYTES)) u_ctl (
    .clk(clk), .rst_n(rst_n), .addr(addr), .en_a(en_a), .en_b(en_b), .en_c(en_c),
    .strobe_cpu(strobe_cpu), .strobe_ctl(strobe_ctl), .adv(adv), .lane_we(lane_we),
    .byte_we(byte_we), .all_we(all_we), .interleave(interleave), .sleep(sleep),
    .rd_cycle(rd_cycle), .asleep(asleep), .rd_addr(rd_addr), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_mask(wr_mask)
  );

  fts_mem_array #(.ADDR_W(ADDR_W), .BYTES(BYTES)) u_mem (
    .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_mask(wr_mask), .wr_data(wdata),
    .rd_addr(rd_addr), .rd_data(arr_q)
  );

  // flow-through read path, gated asynchronously by output enable
  assign rdata_vld = rd_cycle & out_en & ~asleep;
  assign rdata     = rdata_vld ? arr_q : '0;

  // R11: disabled output carries nothing
  a_r11_oe: assert property (@(posedge clk) disable iff (!rst_n)
    !out_en |-> (!rdata_vld && rdata == '0));
  // R12: no valid data while asleep
  a_r12_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    asleep |-> !rdata_vld);
endmodule

// File: tb/fts_sram_tb.sv
module fts_sram_tb;
  localparam int AW = 8;
  localparam int NB = 4;
  localparam int DW = 8 * NB;

  logic clk = 1'b0;
  logic rst_n;
  logic [AW-1:0] addr;
  logic en_a, en_b, en_c, strobe_cpu, strobe_ctl, adv;
  logic [NB-1:0] lane_we;
  logic byte_we, all_we, out_en, interleave, sleep;
  logic [DW-1:0] wdata, rdata;
  logic rdata_vld;

  int total = 0;
  int bad = 0;
  bit done = 0;
  logic [DW-1:0] mdl [256];

  always #10 clk = ~clk;

  fts_sram #(.ADDR_W(AW), .BYTES(NB)) u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .en_a(en_a), .en_b(en_b), .en_c(en_c),
    .strobe_cpu(strobe_cpu), .strobe_ctl(strobe_ctl), .adv(adv), .lane_we(lane_we),
    .byte_we(byte_we), .all_we(all_we), .out_en(out_en), .interleave(interleave),
    .sleep(sleep), .wdata(wdata), .rdata(rdata), .rdata_vld(rdata_vld)
  );

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic idle();
    strobe_cpu = 0; strobe_ctl = 0; adv = 0;
    lane_we = '0; byte_we = 0; all_we = 0;
    en_a = 1; en_b = 1; en_c = 1;
  endtask

  task automatic wr_word(input logic [AW-1:0] a, input logic [DW-1:0] d);
    idle();
    strobe_ctl = 1; addr = a; all_we = 1; wdata = d;
    step();
    mdl[a] = d;
    idle();
  endtask

  task automatic chk_read(input string tag, input logic [AW-1:0] a);
    chk({tag, " vld"}, {31'd0, rdata_vld}, 32'd1);
    chk({tag, " data"}, rdata, mdl[a]);
  endtask

  // R13
  task automatic t_reset();
    chk("R13 vld after reset", {31'd0, rdata_vld}, 32'd0);
  endtask

  // R5 and R1: a new address every edge
  task automatic t_back_to_back();
    idle();
    for (int i = 0; i < 8; i++) begin
      strobe_ctl = 1; addr = AW'(8'h10 + i); all_we = 1; wdata = 32'hA000_0000 + i * 32'h111;
      step();
      mdl[8'h10 + i] = 32'hA000_0000 + i * 32'h111;
      chk("R5 write cycle no vld", {31'd0, rdata_vld}, 32'd0);
    end
    idle();
    strobe_ctl = 1;
    addr = 8'h13; step(); chk_read("R1 ctl read 13", 8'h13);
    addr = 8'h10; step(); chk_read("R5 read 10", 8'h10);
    addr = 8'h16; step(); chk_read("R5 read 16", 8'h16);
    idle();
  endtask

  // R2 R3 R14
  task automatic t_burst(input logic ilv, input logic [AW-1:0] start, input string tag);
    logic [AW-1:0] a;
    idle();
    interleave = ilv;
    strobe_cpu = 1; addr = start;
    step();
    chk_read({tag, " beat0"}, start);
    strobe_cpu = 0; adv = 1;
    for (int i = 1; i < 4; i++) begin
      step();
      if (ilv) a = {start[AW-1:2], start[1:0] ^ 2'(i)};
      else     a = {start[AW-1:2], 2'(start[1:0] + 2'(i))};
      chk_read($sformatf("%s beat%0d (R14 upper fixed)", tag, i), a);
    end
    idle();
    interleave = 0;
  endtask

  // R4: hold without advance, for write and read
  task automatic t_hold();
    idle();
    strobe_ctl = 1; addr = 8'h20; all_we = 1; wdata = 32'h0000_00D0;
    step();
    strobe_ctl = 0; adv = 0; wdata = 32'h0000_00D1;
    step();
    adv = 1; wdata = 32'h0000_00D2;
    step();
    mdl[8'h20] = 32'h0000_00D1;
    mdl[8'h21] = 32'h0000_00D2;
    idle();
    strobe_cpu = 1; addr = 8'h20;
    step();
    chk_read("R4 held write landed", 8'h20);
    strobe_cpu = 0; adv = 0;
    step();
    chk_read("R4 read hold", 8'h20);
    adv = 1;
    step();
    chk_read("R4 step after hold", 8'h21);
    idle();
  endtask

  // R6 R7
  task automatic t_bytes();
    wr_word(8'h30, 32'h1122_3344);
    strobe_ctl = 1; addr = 8'h30; byte_we = 1; lane_we = 4'b0101; wdata = 32'hAABB_CCDD;
    step();
    mdl[8'h30] = 32'h11BB_33DD;
    idle();
    strobe_ctl = 1; addr = 8'h30; byte_we = 1; lane_we = 4'b0000; wdata = 32'hFFFF_FFFF;
    step();
    chk_read("R6 lanes 0,2 only / empty mask reads", 8'h30);
    idle();
    strobe_ctl = 1; addr = 8'h30; all_we = 1; byte_we = 1; lane_we = 4'b0001; wdata = 32'h5566_7788;
    step();
    mdl[8'h30] = 32'h5566_7788;
    idle();
    strobe_ctl = 1; addr = 8'h30;
    step();
    chk_read("R7 global write all lanes", 8'h30);
    idle();
  endtask

  // R8 R9
  task automatic t_cpu_strobe();
    idle();
    strobe_cpu = 1; strobe_ctl = 1; en_b = 0; en_c = 0; addr = 8'h30;
    all_we = 1; wdata = 32'hDEAD_BEEF;
    step();
    chk_read("R8 cpu start reads, write ignored", 8'h30);
    idle();
    strobe_ctl = 1; addr = 8'h30;
    step();
    chk_read("R8 word unchanged", 8'h30);
    idle();
    strobe_cpu = 1; addr = 8'h10;
    step();
    strobe_cpu = 1; en_a = 0; addr = 8'h30; adv = 1;
    step();
    en_a = 1;
    chk_read("R9 ignored cpu strobe, burst advanced", 8'h11);
    idle();
  endtask

  // R10
  task automatic t_desel();
    idle();
    strobe_ctl = 1; addr = 8'h10; en_c = 0;
    step();
    chk("R10 partial enables deselect", {31'd0, rdata_vld}, 32'd0);
    idle();
    adv = 1;
    step();
    chk("R10 adv does not reselect", {31'd0, rdata_vld}, 32'd0);
    idle();
  endtask

  // R11
  task automatic t_oe();
    idle();
    strobe_ctl = 1; addr = 8'h12;
    step();
    idle();
    out_en = 0;
    #1;
    chk("R11 vld gated", {31'd0, rdata_vld}, 32'd0);
    chk("R11 data zero", rdata, 32'd0);
    out_en = 1;
    #1;
    chk_read("R11 restored", 8'h12);
  endtask

  // R12
  task automatic t_sleep();
    idle();
    strobe_ctl = 1; addr = 8'h15;
    step();
    idle();
    sleep = 1;
    step();               // edge k samples sleep
    step();               // edge k+1
    chk("R12 vld low while asleep", {31'd0, rdata_vld}, 32'd0);
    strobe_ctl = 1; addr = 8'h15; all_we = 1; wdata = 32'h0BAD_0BAD;
    step();               // edge k+2: ignored
    idle();
    sleep = 0;
    step(); step(); step();
    strobe_ctl = 1; addr = 8'h15;
    step();
    chk_read("R12 contents kept, write ignored", 8'h15);
    idle();
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; addr = '0; wdata = '0; out_en = 1; interleave = 0; sleep = 0;
    idle();
    step(); step();
    rst_n = 1;
    step(); step(); step();
    t_reset();
    t_back_to_back();
    t_burst(1'b0, 8'h12, "R2 linear");
    t_burst(1'b1, 8'h11, "R3 interleaved");
    t_burst(1'b0, 8'h17, "R14 linear wrap");
    t_hold();
    t_bytes();
    t_cpu_strobe();
    t_desel();
    t_oe();
    t_sleep();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule